// File: doc/BRIEF.md
# I2C Slave Receiver With Guarded Receive Buffer

This block is a standard-mode I2C target that watches SCL and SDA with a fast system clock. It detects bus START and STOP conditions and shifts in bytes MSB first on SCL rising edges. It compares the address against a programmable address input, in either 7-bit or 10-bit form, and acknowledges a matching address or data byte by itself. Accepted bytes move from the internal shift register into a single receive buffer that the host reads.

A pending buffer-full or overflow condition blocks the acknowledge and the buffer load, but the interrupt flag is still raised, so the host always learns that a byte went by. On a read transfer the block sends the buffer byte on SDA. It keeps sending that byte for as long as the master acknowledges. The block only ever pulls SDA low or releases it. It never stretches SCL.

Top module: `i2cs_top`

## Requirements
- R1: After reset, rx_data is 0 and buf_full, ovf, start_flag, stop_flag, rw_flag, irq and sda_pull are all 0.
- R2: With en=1 and mode 4'h1 (7-bit), the block acknowledges a first byte whose bits 7:1 equal own_addr[6:0] and whose bit 0 is 0 (write). It holds sda_pull high from the SCL falling edge after the 8th bit until the falling edge of the 9th clock. It loads the byte into rx_data, sets buf_full and sets irq.
- R3: Each data byte that follows a matched write address is acknowledged, loaded into rx_data, sets buf_full and sets irq.
- R4: If buf_full or ovf is 1 when a matched write byte completes, there is no acknowledge and rx_data is unchanged, but irq is set. ovf is set when buf_full was 1.
- R5: A host_rd pulse clears buf_full. ovf stays 1 until an ovf_clr pulse.
- R6: An address that does not match, including the all-zero general call, is not acknowledged and raises no irq. Later bytes are ignored until the next START.
- R7: In mode 4'h2 (10-bit), the first byte must be 11110, then own_addr[9:8], then 0. That byte is acknowledged but not loaded. The second byte must equal own_addr[7:0]. It is then acknowledged and loaded, and data bytes after it are accepted.
- R8: A START sets start_flag and clears stop_flag. A STOP sets stop_flag and clears start_flag.
- R9: START and STOP raise irq only in modes 4'h5 (7-bit), 4'h6 (10-bit) and 4'h8. Mode 4'h8 never acknowledges an address.
- R10: A read address is acknowledged. In 7-bit mode this is own_addr[6:0] with bit 0 = 1. In 10-bit mode it is the header with bit 0 = 1 after a full 10-bit match and a repeated START. The block then sends rx_data MSB first and repeats it after each master ACK. It releases SDA after a master NACK. rw_flag shows 1.
- R11: With en=0, or with any mode other than 4'h1, 4'h2, 4'h5, 4'h6 and 4'h8, sda_pull stays 0, no byte is accepted and start_flag stays 0.
- R12: irq stays 1 until an irq_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| mode | input | 4 | Operating mode select |
| own_addr | input | 10 | Slave address (7-bit modes use bits 6:0) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| host_rd | input | 1 | Pulse: host has read rx_data |
| host_wr | input | 1 | Pulse: write host_wdata into the buffer |
| host_wdata | input | 8 | Byte to transmit on read transfers |
| ovf_clr | input | 1 | Pulse: clear ovf |
| irq_clr | input | 1 | Pulse: clear irq |
| rx_data | output | 8 | Buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while buf_full was set |
| start_flag | output | 1 | START seen last |
| stop_flag | output | 1 | STOP seen last |
| rw_flag | output | 1 | Direction bit of the last matched address |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The assertions check on every cycle that:
- a pending buffer-full or overflow freezes the buffer against a completing byte and still raises the interrupt;
- overflow and the interrupt stay set until they are cleared;
- a host read clears buf_full;
- the START and STOP flags are never set together;
- a disabled or unmatched engine never pulls SDA.

Some behaviour only the bench scenarios can show:
- acknowledges at the right bit;
- the bytes that reach the buffer, which a scoreboard checks;
- 10-bit matching and rejection;
- the transmitted bit order and NACK release on reads;
- the mode-dependent START/STOP interrupts.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_RXD, ST_TXD, ST_WAIT
  } eng_st_t;

  localparam logic [3:0] MODE_A7      = 4'h1;
  localparam logic [3:0] MODE_A10     = 4'h2;
  localparam logic [3:0] MODE_A7_SP   = 4'h5;
  localparam logic [3:0] MODE_A10_SP  = 4'h6;
  localparam logic [3:0] MODE_SP_ONLY = 4'h8;

  localparam logic [4:0] TEN_HDR = 5'b11110;

  function automatic logic mode_slave(input logic [3:0] m);
    return (m == MODE_A7) || (m == MODE_A10) || (m == MODE_A7_SP) || (m == MODE_A10_SP);
  endfunction

  function automatic logic mode_sp_irq(input logic [3:0] m);
    return (m == MODE_A7_SP) || (m == MODE_A10_SP) || (m == MODE_SP_ONLY);
  endfunction

  function automatic logic mode_ten(input logic [3:0] m);
    return (m == MODE_A10) || (m == MODE_A10_SP);
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_p;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_p <= '1;
    else        line_p <= line_s;
  end

  assign scl       = line_s[0];
  assign sda       = line_s[1];
  assign scl_rise  = line_s[0] & ~line_p[0];
  assign scl_fall  = ~line_s[0] & line_p[0];
  assign start_det = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
  assign stop_det  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ten_bit,
  input  logic [AW-1:0] own_addr,
  input  logic          busy,
  input  logic [DW-1:0] tx_byte,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_low,
  output logic          byte_ok,
  output logic          byte_rd,
  output logic          rw,
  output logic [DW-1:0] byte_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_st_t       st, st_n;
  logic [CW-1:0] bitcnt, bitcnt_n;
  logic [DW-1:0] sr, sr_n, tx_sr, tx_sr_n;
  logic          ack_ph, ack_ph_n, sda_low_n, mack, mack_n;
  logic          ten_ok, ten_ok_n, rw_n;

  assign byte_data = sr;

  always_comb begin
    st_n = st; bitcnt_n = bitcnt; sr_n = sr; tx_sr_n = tx_sr;
    ack_ph_n = ack_ph; sda_low_n = sda_low; mack_n = mack;
    ten_ok_n = ten_ok; rw_n = rw;
    byte_ok = 1'b0; byte_rd = 1'b0;
    if (!run) begin
      st_n = ST_IDLE; bitcnt_n = '0; ack_ph_n = 1'b0; sda_low_n = 1'b0;
      ten_ok_n = 1'b0; rw_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADR1; bitcnt_n = '0; ack_ph_n = 1'b0; sda_low_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; bitcnt_n = '0; ack_ph_n = 1'b0; sda_low_n = 1'b0;
      ten_ok_n = 1'b0;
    end else if (st != ST_IDLE && st != ST_WAIT) begin
      if (scl_rise) begin
        if (!ack_ph) begin
          sr_n = {sr[DW-2:0], sda};
          bitcnt_n = bitcnt + 1'b1;
        end else if (st == ST_TXD) begin
          mack_n = ~sda;
        end
      end
      if (scl_fall) begin
        if (ack_ph) begin
          ack_ph_n = 1'b0; bitcnt_n = '0; sda_low_n = 1'b0;
          if (st == ST_TXD) begin
            if (mack) begin
              tx_sr_n = tx_byte;
              sda_low_n = ~tx_byte[DW-1];
            end else begin
              st_n = ST_WAIT;
            end
          end
        end else if (bitcnt == LAST) begin
          ack_ph_n = 1'b1;
          sda_low_n = 1'b0;
          case (st)
            ST_ADR1: begin
              if (!ten_bit) begin
                if (sr[7:1] == own_addr[6:0] && sr[7:1] != 7'd0) begin
                  rw_n = sr[0]; byte_ok = 1'b1; byte_rd = sr[0];
                  if (sr[0]) begin
                    st_n = ST_TXD; sda_low_n = 1'b1; mack_n = 1'b1;
                  end else begin
                    st_n = ST_RXD; sda_low_n = ~busy;
                  end
                end else begin
                  st_n = ST_WAIT;
                end
              end else if (sr[7:3] == TEN_HDR && sr[2:1] == own_addr[9:8]) begin
                if (!sr[0]) begin
                  st_n = ST_ADR2; sda_low_n = 1'b1; rw_n = 1'b0;
                end else if (ten_ok) begin
                  st_n = ST_TXD; sda_low_n = 1'b1; mack_n = 1'b1; rw_n = 1'b1;
                  byte_ok = 1'b1; byte_rd = 1'b1;
                end else begin
                  st_n = ST_WAIT;
                end
              end else begin
                st_n = ST_WAIT;
              end
            end
            ST_ADR2: begin
              if (sr == own_addr[7:0]) begin
                st_n = ST_RXD; ten_ok_n = 1'b1; byte_ok = 1'b1; sda_low_n = ~busy;
              end else begin
                st_n = ST_WAIT;
              end
            end
            ST_RXD: begin
              byte_ok = 1'b1; sda_low_n = ~busy;
            end
            default: sda_low_n = 1'b0;
          endcase
        end else if (st == ST_TXD) begin
          tx_sr_n = {tx_sr[DW-2:0], 1'b0};
          sda_low_n = ~tx_sr[DW-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sr <= '0; tx_sr <= '0;
      ack_ph <= 1'b0; sda_low <= 1'b0; mack <= 1'b0; ten_ok <= 1'b0; rw <= 1'b0;
    end else begin
      st <= st_n; bitcnt <= bitcnt_n; sr <= sr_n; tx_sr <= tx_sr_n;
      ack_ph <= ack_ph_n; sda_low <= sda_low_n; mack <= mack_n;
      ten_ok <= ten_ok_n; rw <= rw_n;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sda_low); // R11
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WAIT |-> !sda_low); // R6
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok && !byte_rd && busy |=> !sda_low); // R4

endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] own_addr,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          ovf_clr,
  input  logic          irq_clr,
  output logic [DW-1:0] rx_data,
  output logic          buf_full,
  output logic          ovf,
  output logic          start_flag,
  output logic          stop_flag,
  output logic          rw_flag,
  output logic          irq
);
  logic [1:0] rst_sh;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_core_n = rst_sh[1];

  logic slave_on, sp_on, active;
  assign slave_on = en & mode_slave(mode);
  assign sp_on    = en & mode_sp_irq(mode);
  assign active   = slave_on | sp_on;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl(scl_s), .sda(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic          busy, byte_ok, byte_rd, sda_low, eng_rw;
  logic [DW-1:0] byte_data;
  logic [DW-1:0] rx_buf, rx_buf_n;
  logic          full_n, ovf_n, irq_n, s_n, p_n;
  logic          load;

  assign busy = buf_full | ovf;

  i2cs_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .run(slave_on), .ten_bit(mode_ten(mode)),
    .own_addr(own_addr), .busy(busy), .tx_byte(rx_buf), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_low(sda_low), .byte_ok(byte_ok),
    .byte_rd(byte_rd), .rw(eng_rw), .byte_data(byte_data)
  );

  always_comb begin
    load     = byte_ok & ~byte_rd & ~busy;
    rx_buf_n = load ? byte_data : (host_wr ? host_wdata : rx_buf);
    full_n   = load ? 1'b1 : (host_rd ? 1'b0 : buf_full);
    ovf_n    = (byte_ok & ~byte_rd & buf_full) ? 1'b1 : (ovf_clr ? 1'b0 : ovf);
    irq_n    = (byte_ok | (sp_on & (start_det | stop_det))) ? 1'b1
             : (irq_clr ? 1'b0 : irq);
    s_n      = !active ? 1'b0 : start_det ? 1'b1 : stop_det ? 1'b0 : start_flag;
    p_n      = !active ? 1'b0 : stop_det ? 1'b1 : start_det ? 1'b0 : stop_flag;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rx_buf <= '0; buf_full <= 1'b0; ovf <= 1'b0; irq <= 1'b0;
      start_flag <= 1'b0; stop_flag <= 1'b0;
    end else begin
      rx_buf <= rx_buf_n; buf_full <= full_n; ovf <= ovf_n; irq <= irq_n;
      start_flag <= s_n; stop_flag <= p_n;
    end
  end

  assign rx_data  = rx_buf;
  assign rw_flag  = eng_rw;
  assign sda_pull = sda_low;

  AST_BUSY_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_core_n)
    byte_ok && !byte_rd && busy && !host_wr |=> $stable(rx_data)); // R4
  AST_BUSY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    byte_ok |=> irq); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    ovf && !ovf_clr |=> ovf); // R5
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_rd && !byte_ok |=> !buf_full); // R5
  AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(start_flag && stop_flag)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq && !irq_clr |=> irq); // R12
  AST_SP_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_core_n)
    !irq && !byte_ok && !sp_on |=> !irq); // R9

endmodule

// File: tb/i2cs_top_test.sv
module i2cs_top_test;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] mode = 4'h0;
  logic [9:0] own_addr = 10'h03A;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic host_rd = 1'b0, host_wr = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic sda_pull, buf_full, ovf, start_flag, stop_flag, rw_flag, irq;
  logic [7:0] rx_data;
  logic sda_line;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2cs_top uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .own_addr(own_addr),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .ovf_clr(ovf_clr),
    .irq_clr(irq_clr), .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf),
    .start_flag(start_flag), .stop_flag(stop_flag), .rw_flag(rw_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input logic loads,
                           input string tag);
    logic got;
    if (loads) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    got = (sda_line == 1'b0);
    wq(1); scl_m = 1'b0; wq(1);
    chk({tag, " ack"}, got, exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
    logic [7:0] got;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1'b1; wq(1); got[i] = sda_line; wq(1); scl_m = 1'b0;
    end
    wq(1);
    sda_m = ~mack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1); sda_m = 1'b1;
    chk({tag, " tx byte"}, got, exp);
  endtask

  task automatic pulse_rd();
    @(negedge clk) host_rd = 1'b1; @(negedge clk) host_rd = 1'b0; @(negedge clk);
  endtask
  task automatic pulse_irq_clr();
    @(negedge clk) irq_clr = 1'b1; @(negedge clk) irq_clr = 1'b0; @(negedge clk);
  endtask
  task automatic pulse_ovf_clr();
    @(negedge clk) ovf_clr = 1'b1; @(negedge clk) ovf_clr = 1'b0; @(negedge clk);
  endtask
  task automatic host_write(input logic [7:0] b);
    @(negedge clk) begin host_wr = 1'b1; host_wdata = b; end
    @(negedge clk) host_wr = 1'b0; @(negedge clk);
  endtask

  // scoreboard monitor: every buffer load is compared with the queued byte
  initial begin
    forever begin
      @(posedge buf_full);
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected load actual=%0h expected=none", rx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          fails++;
          $display("FAIL R3 buffer load actual=%0h expected=%0h", rx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset flags", {rx_data, buf_full, ovf, start_flag, stop_flag, rw_flag, irq, sda_pull},
        32'h0);

    // 7-bit write
    en = 1'b1; mode = 4'h1; own_addr = 10'h03A; wq(1);
    bus_start();
    chk("R8 start flag", {start_flag, stop_flag}, 2'b10);
    send_byte(8'h74, 1'b1, 1'b1, "R2 addr");
    chk("R2 buf_full irq", {buf_full, irq}, 2'b11);
    pulse_rd();
    chk("R5 read clears full", buf_full, 1'b0);
    pulse_irq_clr();
    send_byte(8'hA5, 1'b1, 1'b1, "R3 data A5");
    chk("R3 irq", irq, 1'b1);
    pulse_rd();
    send_byte(8'h5A, 1'b1, 1'b1, "R3 data 5A");
    pulse_irq_clr();
    send_byte(8'h33, 1'b0, 1'b0, "R4 full nack");
    chk("R4 buffer kept", rx_data, 8'h5A);
    chk("R4 ovf and irq", {ovf, irq}, 2'b11);
    pulse_rd();
    chk("R5 ovf stays", {buf_full, ovf}, 2'b01);
    send_byte(8'h77, 1'b0, 1'b0, "R4 ovf nack");
    pulse_ovf_clr();
    chk("R5 ovf cleared", ovf, 1'b0);
    send_byte(8'h77, 1'b1, 1'b1, "R3 after clear");
    pulse_rd();
    pulse_irq_clr();
    repeat (40) @(negedge clk);
    chk("R12 irq stays clear", irq, 1'b0);
    bus_stop();
    chk("R8 stop flag", {start_flag, stop_flag}, 2'b01);
    chk("R9 no stop irq in mode 1", irq, 1'b0);

    // address mismatch and general call
    bus_start();
    send_byte(8'h44, 1'b0, 1'b0, "R6 mismatch");
    send_byte(8'h11, 1'b0, 1'b0, "R6 ignored data");
    chk("R6 no irq no load", {irq, buf_full}, 2'b00);
    bus_stop();
    bus_start();
    send_byte(8'h00, 1'b0, 1'b0, "R6 general call");
    chk("R6 gc no irq", irq, 1'b0);
    bus_stop();

    // 7-bit read
    host_write(8'h96);
    bus_start();
    send_byte(8'h75, 1'b1, 1'b0, "R10 read addr");
    chk("R10 rw flag", rw_flag, 1'b1);
    recv_byte(8'h96, 1'b1, "R10 first");
    recv_byte(8'h96, 1'b0, "R10 second");
    wq(1);
    chk("R10 released after nack", sda_pull, 1'b0);
    bus_stop();
    pulse_irq_clr();

    // start/stop interrupt modes
    mode = 4'h5; wq(1);
    bus_start();
    chk("R9 start irq mode 5", irq, 1'b1);
    pulse_irq_clr();
    bus_stop();
    chk("R9 stop irq mode 5", irq, 1'b1);
    pulse_irq_clr();
    mode = 4'h8; wq(1);
    bus_start();
    chk("R9 start irq mode 8", irq, 1'b1);
    send_byte(8'h74, 1'b0, 1'b0, "R9 idle no ack");
    bus_stop();
    pulse_irq_clr();

    // 10-bit
    mode = 4'h2; own_addr = 10'h2C5; wq(1);
    bus_start();
    send_byte(8'hF4, 1'b1, 1'b0, "R7 header");
    send_byte(8'hC4, 1'b0, 1'b0, "R7 wrong low byte");
    chk("R7 no load", buf_full, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'hF4, 1'b1, 1'b0, "R7 header again");
    send_byte(8'hC5, 1'b1, 1'b1, "R7 low byte");
    pulse_rd();
    send_byte(8'h3E, 1'b1, 1'b1, "R7 data");
    pulse_rd();
    host_write(8'h3C);
    bus_start();
    send_byte(8'hF5, 1'b1, 1'b0, "R10 ten read hdr");
    recv_byte(8'h3C, 1'b0, "R10 ten read");
    bus_stop();
    pulse_irq_clr();

    // disabled and unlisted mode
    en = 1'b0; mode = 4'h1; own_addr = 10'h03A; wq(1);
    bus_start();
    chk("R11 no start flag", start_flag, 1'b0);
    send_byte(8'h74, 1'b0, 1'b0, "R11 disabled");
    bus_stop();
    en = 1'b1; mode = 4'h3; wq(1);
    bus_start();
    send_byte(8'h74, 1'b0, 1'b0, "R11 bad mode");
    chk("R11 nothing loaded", {buf_full, irq}, 2'b00);
    bus_stop();

    wq(2);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule